// File: doc/BRIEF.md
# Serial-Bus Slave Controller for a 256-Byte Non-Volatile Memory

This block is the bus-side control logic for a 256 x 8 non-volatile memory that sits behind a two-wire serial bus. It watches the bus clock and data lines after oversampling them on the system clock and finds START and STOP conditions. It compares the 7-bit device address against a fixed 4-bit family code and three chip-select pins. It answers each accepted byte with an acknowledge by enabling an open-drain pull on the data line.

During a write transfer the first byte after the device address loads an 8-bit word pointer. Each data byte after that goes into an eight-slot byte latch. The slot index is the low three bits of the target address. Only those three bits advance from byte to byte, so a transfer wraps inside its 8-byte row. When the transfer ends with STOP, the block sends one start pulse to an external erase/write sequencer. With that pulse it presents the row number, a mask of the filled slots, the latched bytes and a flag that separates a full-row (page) job from a partial one. While the sequencer reports busy, the device address is not acknowledged.

During a read the block fetches bytes from a synchronous memory port with one cycle of latency. It shifts them out MSB first and advances the full 8-bit pointer after each byte. The read goes on until the master withholds its acknowledge.

Top module: `eeprom_bus_slave`

## Requirements
- R1: The device responds only to an address byte whose upper seven bits, MSB first, are 0,0,1,0 followed by chip_sel_i[2], chip_sel_i[1] and chip_sel_i[0]. Bit 0 of that byte selects read (1) or write (0). On any other address the block pulls nothing and ignores every byte until the next START or STOP.
- R2: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. A START in the middle of a byte abandons that byte and begins address reception again. The pull on the data line changes only while the bus clock is low.
- R3: In a write, the device address, the word-address byte and each accepted data byte are acknowledged. Data byte n lands in latch slot (A+n) mod 8, where A is the low three bits of the word address. The upper five pointer bits stay fixed throughout the transfer.
- R4: A STOP that ends a write with 1 to 8 accepted data bytes produces exactly one single-cycle prog_start_o. At that pulse prog_row_o is the upper five word-address bits, bit k of prog_mask_o marks a filled slot k, and prog_data_o[8k+7:8k] holds slot k. prog_page_o is 1 only when all 8 slots are filled.
- R5: A ninth data byte in one write transfer gets no acknowledge. The whole transfer is then dropped, and no prog_start_o follows the STOP.
- R6: While prog_busy_i is high the device address is not acknowledged. Because of that, no programming can start.
- R7: A read that follows the device address directly returns the byte at the current pointer. After reset the pointer is 0, and after a write it is left where the write moved it.
- R8: A random read is a write of the word address with no data bytes, then a repeated START with the read bit set. It returns the byte at that address. A write that a repeated START cuts short never programs.
- R9: After each byte it sends, the block increments the full 8-bit pointer, wrapping from 255 to 0. A sequential read can therefore run across the end of the array.
- R10: When the master does not acknowledge a read byte, the block releases the data line and stays released until the next START or STOP.
- R11: After reset sda_pull_o, prog_start_o and mem_rd_en_o are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| chip_sel_i | input | 3 | Strapped chip-select bits compared against the address byte |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| mem_rd_en_o | output | 1 | Read strobe to the memory port |
| mem_rd_addr_o | output | 8 | Read address (current word pointer) |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the strobe |
| prog_start_o | output | 1 | One-cycle request to the erase/write sequencer |
| prog_page_o | output | 1 | 1 = full 8-byte row job, 0 = partial row |
| prog_row_o | output | 5 | Row number (upper five address bits) |
| prog_mask_o | output | 8 | Slot k holds a byte to program |
| prog_data_o | output | 64 | Slot k in bits 8k+7 down to 8k |
| prog_busy_i | input | 1 | Sequencer busy; device address is refused while high |

## Verification
The bench aims at the row wrap by starting an eight-byte write at offset 5 and reading the row back. A design that carried the increment into the upper address bits would scatter bytes into the next row. It sends a ninth data byte and checks both that the byte goes unacknowledged and that the memory is untouched afterwards; a design that programmed the first eight bytes anyway would fail the readback. Further directed scenarios cover these cases:
- A sequential read across address 255, which exposes a pointer that saturates or also wraps within the row.
- An address byte sent during the busy window, which catches a slave that answers while programming.
- A byte cut short by a repeated START, which would leave a desynchronised bit counter or a stray programming pulse behind it.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    // Controller states; each ACK state is entered only when the slave answers.
    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,   // bus free, waiting for START
        ST_ADDR      = 4'd1,   // shifting in the device address byte
        ST_ADDR_ACK  = 4'd2,   // answering the device address
        ST_WADDR     = 4'd3,   // shifting in the word-address byte
        ST_WADDR_ACK = 4'd4,   // answering the word address
        ST_WDATA     = 4'd5,   // shifting in a data byte
        ST_WDATA_ACK = 4'd6,   // answering an accepted data byte
        ST_RDATA     = 4'd7,   // shifting out a read byte
        ST_RACK      = 4'd8,   // sampling the master's answer
        ST_RNEXT     = 4'd9,   // master answered; next byte is being fetched
        ST_HOLD      = 4'd10   // off the bus until START or STOP
    } ebs_state_e;

endpackage

// File: rtl/ebs_line_sync.sv
module ebs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    // Idle bus is high on both lines, so reset the chains high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_prev  <= scl_now;
            sda_prev  <= sda_now;
        end
    end

    assign scl_now    = scl_chain[STAGES-1];
    assign sda_now    = sda_chain[STAGES-1];
    assign sda_lvl_o  = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    // Data edges count as conditions only while the clock stayed high.
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/ebs_write_latch.sv
module ebs_write_latch #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      wr_i,
    input  logic [$clog2(SLOTS)-1:0]  slot_i,
    input  logic [DATA_W-1:0]         din_i,
    output logic [SLOTS*DATA_W-1:0]   data_o,
    output logic [SLOTS-1:0]          mask_o,
    output logic [$clog2(SLOTS+1)-1:0] count_o,
    output logic                      full_o
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] count_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        logic              valid_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q  <= '0;
                valid_q <= 1'b0;
            end else if (clr_i) begin
                valid_q <= 1'b0;
            end else if (wr_i && (slot_i == SLOT_W'(g))) begin
                byte_q  <= din_i;
                valid_q <= 1'b1;
            end
        end

        assign data_o[g*DATA_W +: DATA_W] = byte_q;
        assign mask_o[g]                  = valid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (wr_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;
    assign full_o  = (count_q == CNT_W'(SLOTS));

endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
    import ebs_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter int         SLOTS       = 8,
    parameter int         CS_W        = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b0010
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 scl_i,
    input  logic                                 sda_i,
    input  logic [CS_W-1:0]                      chip_sel_i,
    output logic                                 sda_pull_o,
    output logic                                 mem_rd_en_o,
    output logic [ADDR_W-1:0]                    mem_rd_addr_o,
    input  logic [DATA_W-1:0]                    mem_rd_data_i,
    output logic                                 prog_start_o,
    output logic                                 prog_page_o,
    output logic [ADDR_W-$clog2(SLOTS)-1:0]      prog_row_o,
    output logic [SLOTS-1:0]                     prog_mask_o,
    output logic [SLOTS*DATA_W-1:0]              prog_data_o,
    input  logic                                 prog_busy_i
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ROW_W  = ADDR_W - SLOT_W;
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int BIT_W  = $clog2(DATA_W + 1);

    ebs_state_e        state;
    ebs_state_e        state_nxt;

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;

    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [ADDR_W-1:0] ptr;
    logic [ROW_W-1:0]  row_q;
    logic              rw_q;
    logic              wr_active;
    logic              discard_q;
    logic              rd_en_q;
    logic              start_q;

    logic              byte_done;
    logic              addr_hit;
    logic              lat_clr;
    logic              lat_wr;
    logic              lat_full;
    logic [CNT_W-1:0]  lat_count;

    ebs_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_line_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    ebs_write_latch #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) u_write_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (lat_clr),
        .wr_i    (lat_wr),
        .slot_i  (ptr[SLOT_W-1:0]),
        .din_i   (rx_sh),
        .data_o  (prog_data_o),
        .mask_o  (prog_mask_o),
        .count_o (lat_count),
        .full_o  (lat_full)
    );

    // A received byte is complete on the clock fall after its eighth bit.
    assign byte_done = scl_fall && (bit_cnt == BIT_W'(DATA_W));
    assign addr_hit  = (rx_sh[DATA_W-1:1] == {DEV_CODE, chip_sel_i}) && !prog_busy_i;
    assign lat_clr   = (state == ST_WADDR) && byte_done;
    assign lat_wr    = (state == ST_WDATA) && byte_done && !lat_full && !discard_q;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nxt = state;
        if (stop_det) begin
            state_nxt = ST_IDLE;
        end else if (start_det) begin
            state_nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nxt = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK:  if (scl_fall)  state_nxt = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) state_nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  state_nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nxt = (lat_full || discard_q) ? ST_HOLD : ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && (bit_cnt == BIT_W'(DATA_W - 1))) state_nxt = ST_RACK;
                ST_RACK:      if (scl_rise)  state_nxt = sda_lvl ? ST_HOLD : ST_RNEXT;
                ST_RNEXT:     if (scl_fall)  state_nxt = ST_RDATA;
                ST_HOLD:      state_nxt = ST_HOLD;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            row_q     <= '0;
            rw_q      <= 1'b0;
            wr_active <= 1'b0;
            discard_q <= 1'b0;
            rd_en_q   <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            rd_en_q <= 1'b0;
            start_q <= 1'b0;
            if (start_det) begin
                bit_cnt   <= '0;
                wr_active <= 1'b0;
            end else if (stop_det) begin
                bit_cnt   <= '0;
                wr_active <= 1'b0;
                if (wr_active && !discard_q && (lat_count != '0)) begin
                    start_q <= 1'b1;
                end
            end else begin
                unique case (state)
                    ST_ADDR, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[DATA_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + BIT_W'(1);
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                rw_q <= rx_sh[0];
                                if (addr_hit && rx_sh[0]) begin
                                    rd_en_q <= 1'b1;
                                end
                            end else if (state == ST_WADDR) begin
                                ptr       <= ADDR_W'(rx_sh);
                                row_q     <= rx_sh[ADDR_W-1:SLOT_W];
                                wr_active <= 1'b1;
                                discard_q <= 1'b0;
                            end else if (lat_wr) begin
                                ptr <= {ptr[ADDR_W-1:SLOT_W], ptr[SLOT_W-1:0] + SLOT_W'(1)};
                            end else begin
                                discard_q <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_RNEXT: begin
                        if (scl_fall && (rw_q || (state == ST_RNEXT))) begin
                            tx_sh   <= mem_rd_data_i;
                            ptr     <= ptr + ADDR_W'(1);
                            bit_cnt <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall && (bit_cnt != BIT_W'(DATA_W - 1))) begin
                            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + BIT_W'(1);
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && !sda_lvl) begin
                            rd_en_q <= 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                                sda_pull_o = ~tx_sh[DATA_W-1];
            default:                                 sda_pull_o = 1'b0;
        endcase
    end

    assign mem_rd_en_o   = rd_en_q;
    assign mem_rd_addr_o = ptr;
    assign prog_start_o  = start_q;
    assign prog_page_o   = (lat_count == CNT_W'(SLOTS));
    assign prog_row_o    = row_q;

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker
    import ebs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOTS  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        scl_i,
    input logic                        sda_pull_o,
    input logic                        mem_rd_en_o,
    input logic [ADDR_W-1:0]           mem_rd_addr_o,
    input logic                        prog_start_o,
    input logic                        prog_page_o,
    input logic [SLOTS-1:0]            prog_mask_o,
    input logic                        prog_busy_i,
    input ebs_state_e                  state,
    input logic [$clog2(SLOTS+1)-1:0]  lat_count
);

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);                                    // R2

    AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !prog_start_o);                                     // R4

    AST_PROG_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> (prog_mask_o != '0));                               // R4

    AST_PAGE_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> (prog_page_o == (prog_mask_o == '1)));              // R4

    AST_LATCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lat_count <= ($clog2(SLOTS+1))'(SLOTS));                             // R5

    AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy_i |-> !prog_start_o);                                      // R6

    AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR_ACK) && ($past(state) != ST_ADDR_ACK)) |-> !$past(prog_busy_i)); // R6

    AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> $stable(mem_rd_addr_o));                             // R9

endmodule

bind eeprom_bus_slave ebs_checker #(
    .ADDR_W (ADDR_W),
    .SLOTS  (SLOTS)
) u_ebs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_pull_o    (sda_pull_o),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_rd_addr_o (mem_rd_addr_o),
    .prog_start_o  (prog_start_o),
    .prog_page_o   (prog_page_o),
    .prog_mask_o   (prog_mask_o),
    .prog_busy_i   (prog_busy_i),
    .state         (state),
    .lat_count     (lat_count)
);

// File: tb/eeprom_bus_slave_bench.sv
`timescale 1ns/1ps
module eeprom_bus_slave_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  chip_sel = 3'b101;
    logic        sda_pull;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_addr;
    logic [7:0]  rdata;
    logic        prog_start;
    logic        prog_page;
    logic [4:0]  prog_row;
    logic [7:0]  prog_mask;
    logic [63:0] prog_data;
    logic        prog_busy;
    logic        sda_bus;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    logic [7:0]  mem [256];
    int          busy_cnt;
    int          prog_events;
    logic        cap_page;
    logic [7:0]  cap_mask;

    localparam logic [7:0] ADR_W = 8'h2A;  // 0010 101 0
    localparam logic [7:0] ADR_R = 8'h2B;  // 0010 101 1

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    eeprom_bus_slave u_eeprom_bus_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .chip_sel_i    (chip_sel),
        .sda_pull_o    (sda_pull),
        .mem_rd_en_o   (mem_rd_en),
        .mem_rd_addr_o (mem_rd_addr),
        .mem_rd_data_i (rdata),
        .prog_start_o  (prog_start),
        .prog_page_o   (prog_page),
        .prog_row_o    (prog_row),
        .prog_mask_o   (prog_mask),
        .prog_data_o   (prog_data),
        .prog_busy_i   (prog_busy)
    );

    // Memory array and erase/write sequencer model.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            busy_cnt    <= 0;
            prog_events <= 0;
            cap_page    <= 1'b0;
            cap_mask    <= 8'h00;
            rdata       <= 8'h00;
        end else begin
            if (mem_rd_en) rdata <= mem[mem_rd_addr];
            if (prog_start) begin
                prog_events <= prog_events + 1;
                cap_page    <= prog_page;
                cap_mask    <= prog_mask;
                busy_cnt    <= 400;
                for (int k = 0; k < 8; k++)
                    if (prog_mask[k]) mem[{prog_row, 3'(k)}] <= prog_data[k*8 +: 8];
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end
    assign prog_busy = (busy_cnt != 0);

    function automatic logic [7:0] init_val(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic half();
        cyc(8);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; half();
            scl_m = 1'b1; half();
            scl_m = 1'b0; cyc(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; half();
        scl_m = 1'b1; cyc(4);
        ack = ~sda_bus;
        cyc(4);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack);
        b = 8'h00;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            half();
            scl_m = 1'b1; cyc(4);
            b = {b[6:0], sda_bus};
            cyc(4);
            scl_m = 1'b0;
        end
        cyc(2);
        sda_m = ~m_ack; half();
        scl_m = 1'b1; half();
        scl_m = 1'b0; cyc(2);
        sda_m = 1'b1;
    endtask

    task automatic wait_idle();
        while (prog_busy) @(negedge clk);
        cyc(4);
    endtask

    // Random read of n bytes starting at a, compared with exp[0..n-1].
    task automatic rand_read(input string tag, input logic [7:0] a, input int n,
                             input logic [7:0] exp [8]);
        logic       ack;
        logic [7:0] got;
        bus_start();
        send_byte(ADR_W, ack); check({tag, " dummy-write address ack"}, ack, 1'b1);
        send_byte(a, ack);     check({tag, " word address ack"}, ack, 1'b1);
        bus_start();
        send_byte(ADR_R, ack); check({tag, " read address ack"}, ack, 1'b1);
        for (int j = 0; j < n; j++) begin
            recv_byte(got, j != n - 1);
            check($sformatf("%s byte %0d", tag, j), got, exp[j]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check("R11 sda_pull after reset", sda_pull, 1'b0);
        check("R11 prog_start after reset", prog_start, 1'b0);
        check("R11 mem_rd_en after reset", mem_rd_en, 1'b0);
        check("R11 pointer after reset", mem_rd_addr, 8'h00);
    endtask

    task automatic t_mismatch();
        logic ack;
        int   ev0 = prog_events;
        bus_start();
        send_byte(8'h26, ack); check("R1 wrong chip-select not acked", ack, 1'b0);
        send_byte(8'h00, ack); check("R1 following byte ignored", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h6A, ack); check("R1 wrong family code not acked", ack, 1'b0);
        bus_stop();
        cyc(4);
        check("R1 no programming after foreign address", prog_events, ev0);
    endtask

    task automatic t_current_read();
        logic       ack;
        logic [7:0] got;
        bus_start();
        send_byte(ADR_R, ack); check("R1 own read address acked", ack, 1'b1);
        recv_byte(got, 1'b0);  check("R7 current-address read at 0", got, init_val(8'h00));
        check("R10 data line released after master nack", sda_pull, 1'b0);
        half();
        check("R10 still released before STOP", sda_pull, 1'b0);
        bus_stop();
        bus_start();
        send_byte(ADR_R, ack);
        recv_byte(got, 1'b0);  check("R7 current-address read advanced to 1", got, init_val(8'h01));
        bus_stop();
    endtask

    task automatic t_byte_write_and_busy();
        logic       ack;
        logic [7:0] exp [8];
        int         ev0 = prog_events;
        bus_start();
        send_byte(ADR_W, ack); check("R3 write address ack", ack, 1'b1);
        send_byte(8'h13, ack); check("R3 word address ack", ack, 1'b1);
        send_byte(8'hAA, ack); check("R3 data byte 0 ack", ack, 1'b1);
        send_byte(8'hBB, ack); check("R3 data byte 1 ack", ack, 1'b1);
        bus_stop();
        cyc(4);
        check("R4 one programming pulse", prog_events, ev0 + 1);
        check("R4 partial-row flag", cap_page, 1'b0);
        check("R4 slot mask 3 and 4", cap_mask, 8'h18);
        // Busy window: own address refused.
        bus_start();
        send_byte(ADR_W, ack); check("R6 address refused while busy", ack, 1'b0);
        bus_stop();
        check("R6 busy still asserted during probe", prog_busy, 1'b1);
        wait_idle();
        check("R6 no extra programming", prog_events, ev0 + 1);
        exp[0] = 8'hAA; exp[1] = 8'hBB;
        for (int j = 2; j < 8; j++) exp[j] = 8'h00;
        rand_read("R8 random read of written bytes", 8'h13, 2, exp);
    endtask

    task automatic t_page_wrap();
        logic       ack;
        logic [7:0] exp [8];
        int         ev0 = prog_events;
        bus_start();
        send_byte(ADR_W, ack);
        send_byte(8'h2D, ack);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'hC0 + 8'(k), ack);
            check($sformatf("R3 page data byte %0d ack", k), ack, 1'b1);
        end
        bus_stop();
        cyc(4);
        check("R4 page programming pulse", prog_events, ev0 + 1);
        check("R4 page flag set for 8 bytes", cap_page, 1'b1);
        check("R4 page mask full", cap_mask, 8'hFF);
        wait_idle();
        for (int j = 0; j < 8; j++) exp[j] = 8'hC0 + 8'((j - 5) & 7);
        rand_read("R3 row wrap readback", 8'h28, 8, exp);
    endtask

    task automatic t_overlong();
        logic       ack;
        logic [7:0] exp [8];
        int         ev0 = prog_events;
        bus_start();
        send_byte(ADR_W, ack);
        send_byte(8'h40, ack);
        for (int k = 0; k < 8; k++) send_byte(8'h90 + 8'(k), ack);
        check("R5 eighth byte still acked", ack, 1'b1);
        send_byte(8'h99, ack);
        check("R5 ninth byte not acked", ack, 1'b0);
        bus_stop();
        cyc(4);
        check("R5 over-long transfer not programmed", prog_events, ev0);
        for (int j = 0; j < 8; j++) exp[j] = init_val(8'h40 + 8'(j));
        rand_read("R5 row untouched", 8'h40, 2, exp);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] exp [8];
        for (int j = 0; j < 8; j++) exp[j] = init_val(8'hFE + 8'(j));
        rand_read("R9 sequential read across 255", 8'hFE, 3, exp);
    endtask

    task automatic t_abort();
        logic       ack;
        logic [7:0] got;
        logic [7:0] exp [8];
        int         ev0 = prog_events;
        bus_start();
        send_byte(ADR_W, ack);
        send_byte(8'h50, ack);
        send_byte(8'h11, ack); check("R3 data byte before abort acked", ack, 1'b1);
        send_bits(8'h60, 3);
        bus_start();
        send_byte(ADR_R, ack); check("R2 address reception restarts after mid-byte START", ack, 1'b1);
        recv_byte(got, 1'b0);  check("R2 read continues from advanced pointer", got, init_val(8'h51));
        bus_stop();
        cyc(4);
        check("R8 write cut by repeated START not programmed", prog_events, ev0);
        for (int j = 0; j < 8; j++) exp[j] = init_val(8'h50 + 8'(j));
        rand_read("R8 aborted row unchanged", 8'h50, 1, exp);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_mismatch();
        t_current_read();
        t_byte_write_and_busy();
        t_page_wrap();
        t_overlong();
        t_seq_wrap();
        t_abort();
        cyc(10);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule